// File: doc/BRIEF.md
# Virtual Interface Maintenance Status Generator

This block watches the slot table of a virtual interrupt interface and tells the hypervisor when that table needs attention. Each slot carries a two-bit state, a hardware-linked flag and a notify-on-completion flag. From these, together with the hypervisor's enables and the two virtual group enables, the block derives an eight-bit status word, a bitmap of slots whose completion must be reported, a bitmap of slots free for reuse, and one maintenance interrupt line.

The block also holds the counter of completions that found no matching slot. A one-cycle pulse on `eoi_miss` advances it. Every other output is purely combinational, so it follows the present slot table and enables in the same cycle. Writing the slots and routing the maintenance line are left to the surrounding logic.

Top module: `vgic_maint_status`

## Requirements
- R1: Bit i of `eoi_map` is 1 exactly when slot i is idle (state 2'b00), its hardware flag is 0 and its notify flag is 1.
- R2: Bit i of `empty_map` is 1 exactly when slot i is idle and either its hardware flag is 1 or its notify flag is 0.
- R3: `stat_word[0]` (completion) is 1 when `eoi_map` is nonzero.
- R4: `stat_word[1]` (underflow) is 1 when `ie_underflow` is 1 and fewer than two slots are non-idle.
- R5: `stat_word[2]` (missed-entry) is 1 when `ie_missed` is 1 and `eoi_count` is nonzero.
- R6: `stat_word[3]` (no-pending) is 1 when `ie_nopend` is 1 and no slot has state 2'b01 (pending) or 2'b11 (pending and active).
- R7: `stat_word[4]` = `ie_g0_on & vg0_enable`, `stat_word[5]` = `ie_g0_off & ~vg0_enable`, `stat_word[6]` = `ie_g1_on & vg1_enable`, `stat_word[7]` = `ie_g1_off & ~vg1_enable`.
- R8: `eoi_count` is 0 after reset, rises by one on each clock edge where `eoi_miss` is 1, and holds otherwise.
- R9: `eoi_count` wraps from its maximum value (31 by default) to 0.
- R10: `maint_irq` is 1 exactly when `hyp_enable` is 1 and at least one bit of `stat_word` is 1.
- R11: All outputs except `eoi_count` change in the same cycle as the inputs they depend on, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_state | input | 2*NUM_SLOTS | State of each slot, slot i in bits [2i+1:2i]: 00 idle, 01 pending, 10 active, 11 pending and active |
| slot_hw | input | NUM_SLOTS | Hardware-linked flag per slot |
| slot_eoi | input | NUM_SLOTS | Notify-on-completion flag per slot |
| hyp_enable | input | 1 | Global hypervisor enable for the maintenance line |
| ie_underflow | input | 1 | Enable for the underflow status bit |
| ie_missed | input | 1 | Enable for the missed-entry status bit |
| ie_nopend | input | 1 | Enable for the no-pending status bit |
| ie_g0_on | input | 1 | Enable for the group-0-enabled status bit |
| ie_g0_off | input | 1 | Enable for the group-0-disabled status bit |
| ie_g1_on | input | 1 | Enable for the group-1-enabled status bit |
| ie_g1_off | input | 1 | Enable for the group-1-disabled status bit |
| vg0_enable | input | 1 | Virtual group 0 enable |
| vg1_enable | input | 1 | Virtual group 1 enable |
| eoi_miss | input | 1 | Pulse: a completion found no matching slot |
| stat_word | output | 8 | Maintenance status bits |
| eoi_map | output | NUM_SLOTS | Slots whose completion is to be reported |
| empty_map | output | NUM_SLOTS | Idle slots free for reuse |
| eoi_count | output | CNT_W | Count of unmatched completions |
| maint_irq | output | 1 | Maintenance interrupt line |

## Verification
The bench builds the block with its default parameters, sixteen slots and a five-bit counter. At that size the maps are checked over all sixteen positions, including patterns where every slot is idle. The underflow threshold is checked on both sides, at one and two live slots. Thirty-two pulses carry the counter through its full range and back to zero, so the wrap is observed directly.

// File: rtl/vms_pkg.sv
// Package: shared slot-state encoding and status-word bit positions for the
// maintenance status generator. Assumes a two-bit slot state.
package vms_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE     = 2'b00,
        SLOT_PEND     = 2'b01,
        SLOT_ACT      = 2'b10,
        SLOT_PEND_ACT = 2'b11
    } slot_state_e;

    localparam int STAT_W      = 8;
    localparam int ST_EOI      = 0;
    localparam int ST_UNDER    = 1;
    localparam int ST_MISSED   = 2;
    localparam int ST_NOPEND   = 3;
    localparam int ST_G0_ON    = 4;
    localparam int ST_G0_OFF   = 5;
    localparam int ST_G1_ON    = 6;
    localparam int ST_G1_OFF   = 7;
endpackage

// File: rtl/vms_slot_scan.sv
// Module: scans every slot and produces the completion map, the empty map,
// the count of non-idle slots and a flag for any pending slot.
// Assumes slot i occupies bits [2i+1:2i] of slot_state. Purely combinational.
module vms_slot_scan
    import vms_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int CW       = $clog2(NUM_SLOTS + 1)
) (
    input  logic [2*NUM_SLOTS-1:0] slot_state,
    input  logic [NUM_SLOTS-1:0]   slot_hw,
    input  logic [NUM_SLOTS-1:0]   slot_eoi,
    output logic [NUM_SLOTS-1:0]   eoi_map,
    output logic [NUM_SLOTS-1:0]   empty_map,
    output logic [CW-1:0]          live_cnt,
    output logic                   any_pend
);
    logic [NUM_SLOTS-1:0] idle_v;
    logic [NUM_SLOTS-1:0] pend_v;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // per-slot classification of state and flags
        always_comb begin
            idle_v[i]    = (slot_state[2*i +: 2] == SLOT_IDLE);
            pend_v[i]    = slot_state[2*i];
            eoi_map[i]   = idle_v[i] & ~slot_hw[i] & slot_eoi[i];
            empty_map[i] = idle_v[i] & (slot_hw[i] | ~slot_eoi[i]);
        end
    end

    // population count of non-idle slots
    always_comb begin
        live_cnt = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            live_cnt = live_cnt + CW'(!idle_v[k]);
        end
    end

    // any slot carrying the pending bit
    assign any_pend = |pend_v;
endmodule

// File: rtl/vms_status_pack.sv
// Module: combines each hypervisor enable with its slot-wide condition into
// the status word. Assumes inputs already reduced by the slot scanner.
module vms_status_pack
    import vms_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    localparam int CW       = $clog2(NUM_SLOTS + 1)
) (
    input  logic              any_eoi,
    input  logic [CW-1:0]     live_cnt,
    input  logic              any_pend,
    input  logic              cnt_nonzero,
    input  logic              ie_underflow,
    input  logic              ie_missed,
    input  logic              ie_nopend,
    input  logic              ie_g0_on,
    input  logic              ie_g0_off,
    input  logic              ie_g1_on,
    input  logic              ie_g1_off,
    input  logic              vg0_enable,
    input  logic              vg1_enable,
    output logic [STAT_W-1:0] stat_word
);
    localparam logic [CW-1:0] UNDER_LIM = CW'(2);

    // assemble status bits
    always_comb begin
        stat_word            = '0;
        stat_word[ST_EOI]    = any_eoi;
        stat_word[ST_UNDER]  = ie_underflow & (live_cnt < UNDER_LIM);
        stat_word[ST_MISSED] = ie_missed & cnt_nonzero;
        stat_word[ST_NOPEND] = ie_nopend & ~any_pend;
        stat_word[ST_G0_ON]  = ie_g0_on  &  vg0_enable;
        stat_word[ST_G0_OFF] = ie_g0_off & ~vg0_enable;
        stat_word[ST_G1_ON]  = ie_g1_on  &  vg1_enable;
        stat_word[ST_G1_OFF] = ie_g1_off & ~vg1_enable;
    end
endmodule

// File: rtl/vms_miss_counter.sv
// Module: counter of completions that matched no slot. Wraps modulo
// 2**CNT_W. Synchronous active-low reset.
module vms_miss_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    output logic [CNT_W-1:0] count
);
    // advance on each bump, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (bump) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/vgic_maint_status.sv
// Module: top of the maintenance status generator. Wires the slot scanner,
// status packer and miss counter, and gates the maintenance line with the
// global enable. Assumes slot fields are stable register outputs.
module vgic_maint_status
    import vms_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int CNT_W     = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2*NUM_SLOTS-1:0] slot_state,
    input  logic [NUM_SLOTS-1:0]   slot_hw,
    input  logic [NUM_SLOTS-1:0]   slot_eoi,
    input  logic                   hyp_enable,
    input  logic                   ie_underflow,
    input  logic                   ie_missed,
    input  logic                   ie_nopend,
    input  logic                   ie_g0_on,
    input  logic                   ie_g0_off,
    input  logic                   ie_g1_on,
    input  logic                   ie_g1_off,
    input  logic                   vg0_enable,
    input  logic                   vg1_enable,
    input  logic                   eoi_miss,
    output logic [STAT_W-1:0]      stat_word,
    output logic [NUM_SLOTS-1:0]   eoi_map,
    output logic [NUM_SLOTS-1:0]   empty_map,
    output logic [CNT_W-1:0]       eoi_count,
    output logic                   maint_irq
);
    localparam int CW = $clog2(NUM_SLOTS + 1);

    logic [CW-1:0] live_cnt;
    logic          any_pend;

    vms_slot_scan #(.NUM_SLOTS(NUM_SLOTS)) u_scan (
        .slot_state (slot_state),
        .slot_hw    (slot_hw),
        .slot_eoi   (slot_eoi),
        .eoi_map    (eoi_map),
        .empty_map  (empty_map),
        .live_cnt   (live_cnt),
        .any_pend   (any_pend)
    );

    vms_miss_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (eoi_miss),
        .count (eoi_count)
    );

    vms_status_pack #(.NUM_SLOTS(NUM_SLOTS)) u_pack (
        .any_eoi      (|eoi_map),
        .live_cnt     (live_cnt),
        .any_pend     (any_pend),
        .cnt_nonzero  (|eoi_count),
        .ie_underflow (ie_underflow),
        .ie_missed    (ie_missed),
        .ie_nopend    (ie_nopend),
        .ie_g0_on     (ie_g0_on),
        .ie_g0_off    (ie_g0_off),
        .ie_g1_on     (ie_g1_on),
        .ie_g1_off    (ie_g1_off),
        .vg0_enable   (vg0_enable),
        .vg1_enable   (vg1_enable),
        .stat_word    (stat_word)
    );

    // maintenance line: global enable gates any raised status bit
    assign maint_irq = hyp_enable & (|stat_word);
endmodule

// File: rtl/vms_checker.sv
// Module: property checker for the maintenance status generator, bound to
// the top. Observes ports only.
module vms_checker #(
    parameter int NUM_SLOTS = 16,
    parameter int CNT_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 hyp_enable,
    input logic                 eoi_miss,
    input logic [7:0]           stat_word,
    input logic [NUM_SLOTS-1:0] eoi_map,
    input logic [NUM_SLOTS-1:0] empty_map,
    input logic [CNT_W-1:0]     eoi_count,
    input logic                 maint_irq
);
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_miss |=> eoi_count == $past(eoi_count) + 1'b1); // R8
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !eoi_miss |=> $stable(eoi_count)); // R8
    AST_MAPS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_map & empty_map) == '0); // R2
    AST_EOI_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[0] == (eoi_map != '0)); // R3
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !hyp_enable |-> !maint_irq); // R10
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        maint_irq |-> stat_word != '0); // R10
    AST_G0_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_word[4] && stat_word[5])); // R7
    AST_G1_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat_word[6] && stat_word[7])); // R7
endmodule

bind vgic_maint_status vms_checker #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hyp_enable (hyp_enable),
    .eoi_miss   (eoi_miss),
    .stat_word  (stat_word),
    .eoi_map    (eoi_map),
    .empty_map  (empty_map),
    .eoi_count  (eoi_count),
    .maint_irq  (maint_irq)
);

// File: tb/vgic_maint_status_bench.sv
module vgic_maint_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int CW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*N-1:0] slot_state = '0;
    logic [N-1:0]  slot_hw = '0;
    logic [N-1:0]  slot_eoi = '0;
    logic hyp_enable = 0, ie_underflow = 0, ie_missed = 0, ie_nopend = 0;
    logic ie_g0_on = 0, ie_g0_off = 0, ie_g1_on = 0, ie_g1_off = 0;
    logic vg0_enable = 0, vg1_enable = 0, eoi_miss = 0;
    logic [7:0]    stat_word;
    logic [N-1:0]  eoi_map, empty_map;
    logic [CW-1:0] eoi_count;
    logic          maint_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vgic_maint_status #(.NUM_SLOTS(N), .CNT_W(CW)) u_vgic_maint_status (
        .clk(clk), .rst_n(rst_n), .slot_state(slot_state), .slot_hw(slot_hw),
        .slot_eoi(slot_eoi), .hyp_enable(hyp_enable), .ie_underflow(ie_underflow),
        .ie_missed(ie_missed), .ie_nopend(ie_nopend), .ie_g0_on(ie_g0_on),
        .ie_g0_off(ie_g0_off), .ie_g1_on(ie_g1_on), .ie_g1_off(ie_g1_off),
        .vg0_enable(vg0_enable), .vg1_enable(vg1_enable), .eoi_miss(eoi_miss),
        .stat_word(stat_word), .eoi_map(eoi_map), .empty_map(empty_map),
        .eoi_count(eoi_count), .maint_irq(maint_irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_ins();
        slot_state = '0; slot_hw = '0; slot_eoi = '0;
        {hyp_enable, ie_underflow, ie_missed, ie_nopend} = '0;
        {ie_g0_on, ie_g0_off, ie_g1_on, ie_g1_off, vg0_enable, vg1_enable} = '0;
    endtask

    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic pulse_miss();
        @(negedge clk); eoi_miss = 1'b1;
        @(negedge clk); eoi_miss = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        clear_ins(); settle();
        chk("R8", "count after reset", 32'(eoi_count), 0);
        chk("R2", "all idle empty", 32'(empty_map), 32'hFFFF);
        chk("R1", "all idle no eoi", 32'(eoi_map), 0);
        chk("R10", "irq idle", 32'(maint_irq), 0);
    endtask

    task automatic t_maps();
        clear_ins();
        slot_eoi[3] = 1'b1;
        slot_eoi[5] = 1'b1; slot_hw[5] = 1'b1;
        slot_state[2*9 +: 2] = 2'b10; slot_eoi[9] = 1'b1;
        #1;
        chk("R1", "eoi map", 32'(eoi_map), 32'h0008);
        chk("R2", "empty map", 32'(empty_map), 32'hFDF7);
        chk("R3", "eoi status", 32'(stat_word[0]), 1);
        chk("R11", "same cycle irq off", 32'(maint_irq), 0);
        hyp_enable = 1'b1; #1;
        chk("R10", "irq from eoi", 32'(maint_irq), 1);
        slot_eoi[3] = 1'b0; #1;
        chk("R3", "eoi status cleared", 32'(stat_word[0]), 0);
    endtask

    task automatic t_underflow();
        clear_ins(); ie_underflow = 1'b1;
        slot_state[1:0] = 2'b01; slot_eoi = '0; #1;
        chk("R4", "one live slot", 32'(stat_word[1]), 1);
        slot_state[3:2] = 2'b10; #1;
        chk("R4", "two live slots", 32'(stat_word[1]), 0);
        slot_state = '0; ie_underflow = 1'b0; #1;
        chk("R4", "enable off", 32'(stat_word[1]), 0);
    endtask

    task automatic t_nopend();
        clear_ins(); ie_nopend = 1'b1;
        slot_state[1:0] = 2'b10; slot_state[3:2] = 2'b10; #1;
        chk("R6", "only active", 32'(stat_word[3]), 1);
        slot_state[3:2] = 2'b11; #1;
        chk("R6", "pending and active", 32'(stat_word[3]), 0);
        slot_state[3:2] = 2'b01; #1;
        chk("R6", "pending", 32'(stat_word[3]), 0);
    endtask

    task automatic t_groups();
        clear_ins();
        {ie_g0_on, ie_g0_off, ie_g1_on, ie_g1_off} = 4'hF;
        vg0_enable = 1'b1; vg1_enable = 1'b0; slot_hw = '1; #1;
        chk("R7", "g0 on g1 off", 32'(stat_word[7:4]), 32'b1001);
        vg0_enable = 1'b0; vg1_enable = 1'b1; #1;
        chk("R7", "g0 off g1 on", 32'(stat_word[7:4]), 32'b0110);
        ie_g0_off = 1'b0; ie_g1_on = 1'b0; hyp_enable = 1'b1; #1;
        chk("R7", "enables masked", 32'(stat_word), 0);
        chk("R10", "no status no irq", 32'(maint_irq), 0);
    endtask

    task automatic t_counter();
        clear_ins(); ie_missed = 1'b1; hyp_enable = 1'b1; settle();
        chk("R5", "missed with zero count", 32'(stat_word[2]), 0);
        pulse_miss();
        chk("R8", "count after one", 32'(eoi_count), 1);
        chk("R5", "missed nonzero", 32'(stat_word[2]), 1);
        chk("R10", "irq from missed", 32'(maint_irq), 1);
        settle(); settle();
        chk("R8", "count holds", 32'(eoi_count), 1);
        for (int i = 0; i < 30; i++) pulse_miss();
        chk("R9", "count at max", 32'(eoi_count), 31);
        pulse_miss();
        chk("R9", "count wrapped", 32'(eoi_count), 0);
        chk("R5", "missed after wrap", 32'(stat_word[2]), 0);
        hyp_enable = 1'b0; pulse_miss(); #1;
        chk("R10", "irq gated by enable", 32'(maint_irq), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_maps();
        t_underflow();
        t_nopend();
        t_groups();
        t_counter();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule